// File: doc/BRIEF.md
# Page Access Permission Checker

This block sits behind a page-table walker. Once the walk has finished, it takes the permissions collected along the walk, a few fields of the leaf entry, the kind of access, the privilege of the requester and the paging control flags. From these it decides whether the access may go ahead. It merges the basic user, writable and no-execute rights with three further rules: supervisor access prevention, the write-protect override and per-key access or write disabling.

A granted request produces two things. The first is the read/write/execute permission vector that a translation cache may store. The second is the accessed/dirty update the leaf entry needs. A refused request produces a page-fault error code that encodes the cause, exception vector 14 and the faulting virtual address. Every request is answered exactly one clock after it is presented.

Top module: `page_access_check`

## Requirements
- R1: A user-mode access (`priv_user`=1) to a page whose accumulated user bit is 0 is a protection fault.
- R2: Read is permitted unless `sap_mode` is 1 and the page is a user page. Write is permitted only together with read, and then only if the page is writable or the access is supervisor with `ctl_wp`=0.
- R3: Execute is permitted when the effective no-execute bit is 0, and either the access is user or `ctl_sxp` is 0 or the page is not a user page. `acc_nx` has no effect when `ctl_nxe` is 0.
- R4: The key-rights word is selected by page type. A user page uses `ukey_rights` if `ctl_ukey_en` is 1. A supervisor page uses `skey_rights` if `ctl_skey_en` is 1. Otherwise the word is zero and no key check is made.
- R5: For key k = `leaf_pkey`, word bit 2k disables access and removes read and write. Word bit 2k+1 disables writing and removes write only for a user access or when `ctl_wp`=1. Key rights never remove execute.
- R6: A fault caused by key rights has error code bits 5 (key) and 0 (protection) both set. Other permission faults set bit 0 and not bit 5.
- R7: A granted access asserts `upd_accessed`. On a store it also asserts `upd_dirty`. `upd_writeback` is 1 only if the leaf's accessed bit was 0, or the access is a store and the leaf's dirty bit was 0.
- R8: On a grant the write bit (bit 1) of `rsp_perm` is cleared when the leaf is not dirty and the access is not a store. `rsp_perm` is 0 on a fault.
- R9: Error code bit 2 is set for user accesses. Bit 1 is set for stores. Bit 4 is set for fetches only when `ctl_nxe` or `ctl_sxp` is 1.
- R10: `walk_np` gives a fault with base code 0. Otherwise `walk_rsvd` gives base code bit 3. `walk_np` has priority over `walk_rsvd`, and both have priority over permission checks.
- R11: On a fault `rsp_vector` is 14 and `rsp_fault_addr` is the request address. On a grant both are 0. `acc_type` encodes 0 load, 1 store, 2 fetch. `rsp_perm` bits are 0 read, 1 write, 2 execute.
- R12: Results appear one cycle after `req_valid`. With no request, `rsp_valid`, `rsp_grant` and `rsp_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk result present this cycle |
| req_vaddr | input | VA_W | Virtual address of the access |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch |
| priv_user | input | 1 | Access made in user mode |
| sap_mode | input | 1 | Supervisor access prevention active for this access |
| pg_user | input | 1 | Accumulated user permission |
| pg_write | input | 1 | Accumulated writable permission |
| acc_nx | input | 1 | Accumulated no-execute bit |
| leaf_accessed | input | 1 | Leaf accessed bit (entry bit 5) |
| leaf_dirty | input | 1 | Leaf dirty bit (entry bit 6) |
| leaf_pkey | input | KEY_W | Leaf protection key (entry bits 62:59) |
| walk_np | input | 1 | Walk found a non-present entry |
| walk_rsvd | input | 1 | Walk found a reserved-bit violation |
| ctl_wp | input | 1 | Write protect for supervisor |
| ctl_sxp | input | 1 | Supervisor execute prevention on user pages |
| ctl_nxe | input | 1 | No-execute enable |
| ctl_ukey_en | input | 1 | User-page key rights enable |
| ctl_skey_en | input | 1 | Supervisor-page key rights enable |
| ukey_rights | input | 2*2^KEY_W | Key rights word for user pages |
| skey_rights | input | 2*2^KEY_W | Key rights word for supervisor pages |
| rsp_valid | output | 1 | Result valid |
| rsp_grant | output | 1 | Access allowed |
| rsp_fault | output | 1 | Access refused |
| rsp_perm | output | 3 | Permission vector |
| rsp_errcode | output | 6 | Page-fault error code |
| rsp_vector | output | 8 | Exception vector |
| rsp_fault_addr | output | VA_W | Faulting address |
| upd_accessed | output | 1 | Leaf accessed bit to be set |
| upd_dirty | output | 1 | Leaf dirty bit to be set |
| upd_writeback | output | 1 | Leaf must be written back |

## Verification
The bench targets the interactions between rules. Write-disable must be ignored for a supervisor access with write-protect off; a design that always applied it would refuse a legitimate grant. A fetch from an access-disabled key must be granted with execute only, because key rights never remove execute. The key word must be chosen by page type and not by requester privilege; a swapped selection would raise key faults on the wrong pages. The bench also checks the priority of not-present over reserved over permission causes, the fetch bit staying clear when no-execute and execute prevention are both off, and write permission being withheld for clean pages on loads but kept on stores. A design that got any of these wrong would show a wrong error code or permission vector.

// File: rtl/pkperm_pkg.sv
package pkperm_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [2:0] {
        CAUSE_NONE,
        CAUSE_NP,
        CAUSE_RSVD,
        CAUSE_PROT,
        CAUSE_KEY
    } cause_e;

    localparam int ERR_W       = 6;
    localparam int EB_PRESENT  = 0;
    localparam int EB_WRITE    = 1;
    localparam int EB_USER     = 2;
    localparam int EB_RSVD     = 3;
    localparam int EB_FETCH    = 4;
    localparam int EB_KEY      = 5;

    localparam int PERM_R = 0;
    localparam int PERM_W = 1;
    localparam int PERM_X = 2;

    localparam logic [7:0] PF_VECTOR = 8'd14;

    typedef struct packed {
        logic             valid;
        logic             grant;
        logic             fault;
        logic [2:0]       perm;
        logic [ERR_W-1:0] err;
        logic [7:0]       vector;
        logic             set_a;
        logic             set_d;
        logic             wb;
    } rsp_t;

endpackage

// File: rtl/pkperm_base_rights.sv
module pkperm_base_rights (
    input  logic       priv_user,
    input  logic       sap_mode,
    input  logic       pg_user,
    input  logic       pg_write,
    input  logic       eff_nx,
    input  logic       ctl_wp,
    input  logic       ctl_sxp,
    output logic [2:0] perm
);
    import pkperm_pkg::*;

    logic rd_ok;

    always_comb begin
        rd_ok        = !(sap_mode && pg_user);
        perm[PERM_R] = rd_ok;
        perm[PERM_W] = rd_ok && (pg_write || !(priv_user || ctl_wp));
        perm[PERM_X] = !eff_nx && (priv_user || !(ctl_sxp && pg_user));
    end
endmodule

// File: rtl/pkperm_key_rights.sv
module pkperm_key_rights #(
    parameter int KEY_W = 4,
    localparam int NKEYS = 1 << KEY_W,
    localparam int RW_W  = 2 * NKEYS
) (
    input  logic             pg_user,
    input  logic             priv_user,
    input  logic             ctl_wp,
    input  logic             ctl_ukey_en,
    input  logic             ctl_skey_en,
    input  logic [RW_W-1:0]  ukey_rights,
    input  logic [RW_W-1:0]  skey_rights,
    input  logic [KEY_W-1:0] pkey,
    output logic             key_active,
    output logic [2:0]       key_perm
);
    import pkperm_pkg::*;

    logic [RW_W-1:0]  word;
    logic [NKEYS-1:0] ad_vec;
    logic [NKEYS-1:0] wd_vec;

    always_comb begin
        if (pg_user) word = ctl_ukey_en ? ukey_rights : '0;
        else         word = ctl_skey_en ? skey_rights : '0;
    end

    for (genvar k = 0; k < NKEYS; k++) begin : g_key
        assign ad_vec[k] = word[2*k];
        assign wd_vec[k] = word[2*k+1];
    end

    always_comb begin
        key_active = |word;
        key_perm   = 3'b111;
        if (ad_vec[pkey]) begin
            key_perm[PERM_R] = 1'b0;
            key_perm[PERM_W] = 1'b0;
        end else if (wd_vec[pkey] && (priv_user || ctl_wp)) begin
            key_perm[PERM_W] = 1'b0;
        end
    end
endmodule

// File: rtl/pkperm_err_enc.sv
module pkperm_err_enc (
    input  pkperm_pkg::cause_e          cause,
    input  pkperm_pkg::acc_e            acc,
    input  logic                        priv_user,
    input  logic                        ctl_nxe,
    input  logic                        ctl_sxp,
    output logic [pkperm_pkg::ERR_W-1:0] err
);
    import pkperm_pkg::*;

    always_comb begin
        err = '0;
        unique case (cause)
            CAUSE_RSVD: err[EB_RSVD] = 1'b1;
            CAUSE_PROT: err[EB_PRESENT] = 1'b1;
            CAUSE_KEY: begin
                err[EB_PRESENT] = 1'b1;
                err[EB_KEY]     = 1'b1;
            end
            default: err = '0;
        endcase
        if (cause != CAUSE_NONE) begin
            err[EB_USER]  = priv_user;
            err[EB_WRITE] = (acc == ACC_STORE);
            err[EB_FETCH] = (acc == ACC_FETCH) && (ctl_nxe || ctl_sxp);
        end
    end
endmodule

// File: rtl/page_access_check.sv
module page_access_check #(
    parameter int VA_W  = 48,
    parameter int KEY_W = 4,
    localparam int RW_W = 2 * (1 << KEY_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       acc_type,
    input  logic             priv_user,
    input  logic             sap_mode,
    input  logic             pg_user,
    input  logic             pg_write,
    input  logic             acc_nx,
    input  logic             leaf_accessed,
    input  logic             leaf_dirty,
    input  logic [KEY_W-1:0] leaf_pkey,
    input  logic             walk_np,
    input  logic             walk_rsvd,
    input  logic             ctl_wp,
    input  logic             ctl_sxp,
    input  logic             ctl_nxe,
    input  logic             ctl_ukey_en,
    input  logic             ctl_skey_en,
    input  logic [RW_W-1:0]  ukey_rights,
    input  logic [RW_W-1:0]  skey_rights,
    output logic             rsp_valid,
    output logic             rsp_grant,
    output logic             rsp_fault,
    output logic [2:0]       rsp_perm,
    output logic [5:0]       rsp_errcode,
    output logic [7:0]       rsp_vector,
    output logic [VA_W-1:0]  rsp_fault_addr,
    output logic             upd_accessed,
    output logic             upd_dirty,
    output logic             upd_writeback
);
    import pkperm_pkg::*;

    acc_e             acc;
    logic [2:0]       base_perm;
    logic [2:0]       key_perm;
    logic             key_active;
    logic [2:0]       comb_perm;
    logic [1:0]       need_idx;
    cause_e           cause;
    logic [ERR_W-1:0] err;
    logic             is_store;
    rsp_t             rsp_d, rsp_q;
    logic [VA_W-1:0]  addr_d, addr_q;

    always_comb begin
        unique case (acc_type)
            2'd1:    acc = ACC_STORE;
            2'd2:    acc = ACC_FETCH;
            default: acc = ACC_LOAD;
        endcase
    end

    pkperm_base_rights u_base (
        .priv_user (priv_user),
        .sap_mode  (sap_mode),
        .pg_user   (pg_user),
        .pg_write  (pg_write),
        .eff_nx    (acc_nx && ctl_nxe),
        .ctl_wp    (ctl_wp),
        .ctl_sxp   (ctl_sxp),
        .perm      (base_perm)
    );

    pkperm_key_rights #(.KEY_W(KEY_W)) u_key (
        .pg_user     (pg_user),
        .priv_user   (priv_user),
        .ctl_wp      (ctl_wp),
        .ctl_ukey_en (ctl_ukey_en),
        .ctl_skey_en (ctl_skey_en),
        .ukey_rights (ukey_rights),
        .skey_rights (skey_rights),
        .pkey        (leaf_pkey),
        .key_active  (key_active),
        .key_perm    (key_perm)
    );

    always_comb begin
        is_store  = (acc == ACC_STORE);
        need_idx  = (acc == ACC_STORE) ? 2'(PERM_W) :
                    (acc == ACC_FETCH) ? 2'(PERM_X) : 2'(PERM_R);
        comb_perm = key_active ? (base_perm & key_perm) : base_perm;
        if (walk_np)                                cause = CAUSE_NP;
        else if (walk_rsvd)                         cause = CAUSE_RSVD;
        else if (priv_user && !pg_user)             cause = CAUSE_PROT;
        else if (key_active && !key_perm[need_idx]) cause = CAUSE_KEY;
        else if (!comb_perm[need_idx])              cause = CAUSE_PROT;
        else                                        cause = CAUSE_NONE;
    end

    pkperm_err_enc u_err (
        .cause     (cause),
        .acc       (acc),
        .priv_user (priv_user),
        .ctl_nxe   (ctl_nxe),
        .ctl_sxp   (ctl_sxp),
        .err       (err)
    );

    always_comb begin
        rsp_d  = '0;
        addr_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            if (cause == CAUSE_NONE) begin
                rsp_d.grant        = 1'b1;
                rsp_d.perm         = comb_perm;
                rsp_d.perm[PERM_W] = comb_perm[PERM_W] && (leaf_dirty || is_store);
                rsp_d.set_a        = 1'b1;
                rsp_d.set_d        = is_store;
                rsp_d.wb           = !leaf_accessed || (is_store && !leaf_dirty);
            end else begin
                rsp_d.fault  = 1'b1;
                rsp_d.err    = err;
                rsp_d.vector = PF_VECTOR;
                addr_d       = req_vaddr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q  <= '0;
            addr_q <= '0;
        end else begin
            rsp_q  <= rsp_d;
            addr_q <= addr_d;
        end
    end

    assign rsp_valid      = rsp_q.valid;
    assign rsp_grant      = rsp_q.grant;
    assign rsp_fault      = rsp_q.fault;
    assign rsp_perm       = rsp_q.perm;
    assign rsp_errcode    = rsp_q.err;
    assign rsp_vector     = rsp_q.vector;
    assign rsp_fault_addr = addr_q;
    assign upd_accessed   = rsp_q.set_a;
    assign upd_dirty      = rsp_q.set_d;
    assign upd_writeback  = rsp_q.wb;
endmodule

// File: rtl/page_access_check_sva.sv
module page_access_check_sva #(
    parameter int VA_W = 48
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] req_vaddr,
    input logic [1:0]      acc_type,
    input logic            rsp_valid,
    input logic            rsp_grant,
    input logic            rsp_fault,
    input logic [2:0]      rsp_perm,
    input logic [5:0]      rsp_errcode,
    input logic [7:0]      rsp_vector,
    input logic [VA_W-1:0] rsp_fault_addr,
    input logic            upd_accessed,
    input logic            upd_dirty,
    input logic            upd_writeback
);
    // R12
    resp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_valid && $onehot({rsp_grant, rsp_fault})));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(rsp_valid || rsp_grant || rsp_fault));

    // R11
    fault_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_fault -> (rsp_vector == 8'd14 && rsp_fault_addr == $past(req_vaddr))));

    // R11
    grant_needed_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && acc_type <= 2'd2) |=> (rsp_grant -> rsp_perm[$past(acc_type)]));

    // R7
    grant_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && acc_type == 2'd1) |=> (rsp_grant -> (upd_accessed && upd_dirty)));

    // R8
    fault_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_perm == 3'b000 && !upd_accessed && !upd_writeback));

    // R6
    key_has_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_errcode[5] |-> rsp_errcode[0]);
endmodule

bind page_access_check page_access_check_sva #(.VA_W(VA_W)) u_sva (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_vaddr      (req_vaddr),
    .acc_type       (acc_type),
    .rsp_valid      (rsp_valid),
    .rsp_grant      (rsp_grant),
    .rsp_fault      (rsp_fault),
    .rsp_perm       (rsp_perm),
    .rsp_errcode    (rsp_errcode),
    .rsp_vector     (rsp_vector),
    .rsp_fault_addr (rsp_fault_addr),
    .upd_accessed   (upd_accessed),
    .upd_dirty      (upd_dirty),
    .upd_writeback  (upd_writeback)
);

// File: tb/page_access_check_tb.sv
module page_access_check_tb_top;
    localparam int VA_W = 48;
    localparam logic [VA_W-1:0] VA = 48'h1234_5678_9000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid, priv_user, sap_mode, pg_user, pg_write, acc_nx;
    logic [VA_W-1:0] req_vaddr;
    logic [1:0] acc_type;
    logic leaf_accessed, leaf_dirty, walk_np, walk_rsvd;
    logic [3:0] leaf_pkey;
    logic ctl_wp, ctl_sxp, ctl_nxe, ctl_ukey_en, ctl_skey_en;
    logic [31:0] ukey_rights, skey_rights;
    logic rsp_valid, rsp_grant, rsp_fault, upd_accessed, upd_dirty, upd_writeback;
    logic [2:0] rsp_perm;
    logic [5:0] rsp_errcode;
    logic [7:0] rsp_vector;
    logic [VA_W-1:0] rsp_fault_addr;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    page_access_check #(.VA_W(VA_W), .KEY_W(4)) dut_i (.*);

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic defaults();
        req_valid = 1'b1; req_vaddr = VA; acc_type = 2'd0;
        priv_user = 1'b0; sap_mode = 1'b0;
        pg_user = 1'b1; pg_write = 1'b1; acc_nx = 1'b0;
        leaf_accessed = 1'b1; leaf_dirty = 1'b1; leaf_pkey = 4'd0;
        walk_np = 1'b0; walk_rsvd = 1'b0;
        ctl_wp = 1'b0; ctl_sxp = 1'b0; ctl_nxe = 1'b0;
        ctl_ukey_en = 1'b0; ctl_skey_en = 1'b0;
        ukey_rights = '0; skey_rights = '0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic expect_fault(string tag, logic [5:0] code);
        step();
        chk({tag, " fault"}, rsp_fault, 1'b1);
        chk({tag, " code"}, rsp_errcode, code);
    endtask

    task automatic expect_grant(string tag, logic [2:0] perm);
        step();
        chk({tag, " grant"}, rsp_grant, 1'b1);
        chk({tag, " perm"}, rsp_perm, perm);
    endtask

    task automatic t_user_on_sup();
        defaults(); priv_user = 1'b1; pg_user = 1'b0;
        expect_fault("R1 user on sup page", 6'h05);
        chk("R11 vector", rsp_vector, 8'd14);
        chk("R11 fault addr", rsp_fault_addr, VA);
    endtask

    task automatic t_read_rule();
        defaults(); sap_mode = 1'b1;
        expect_fault("R2 sap on user page", 6'h01);
        defaults();
        expect_grant("R2 sup load user page", 3'b111);
        chk("R11 grant vector", rsp_vector, 8'd0);
        chk("R11 grant addr", rsp_fault_addr, '0);
    endtask

    task automatic t_write_rule();
        defaults(); acc_type = 2'd1; pg_write = 1'b0; pg_user = 1'b0;
        expect_grant("R2 sup store ro wp off", 3'b111);
        ctl_wp = 1'b1;
        expect_fault("R2 sup store ro wp on", 6'h03);
        defaults(); acc_type = 2'd1; pg_write = 1'b0; priv_user = 1'b1;
        expect_fault("R2 user store ro", 6'h07);
    endtask

    task automatic t_exec_rule();
        defaults(); acc_type = 2'd2; pg_user = 1'b0; acc_nx = 1'b1; ctl_nxe = 1'b1;
        expect_fault("R3 fetch nx", 6'h11);
        ctl_nxe = 1'b0;
        expect_grant("R3 nx ignored nxe off", 3'b111);
        defaults(); acc_type = 2'd2; ctl_sxp = 1'b1;
        expect_fault("R3 sup fetch user page sxp", 6'h11);
        priv_user = 1'b1;
        expect_grant("R3 user fetch user page sxp", 3'b111);
        defaults(); acc_type = 2'd2; priv_user = 1'b1; pg_user = 1'b0;
        expect_fault("R9 fetch bit off", 6'h05);
    endtask

    task automatic t_keys();
        defaults(); priv_user = 1'b1; leaf_pkey = 4'd3;
        ukey_rights = 32'h40; ctl_ukey_en = 1'b1;
        expect_fault("R5 access disable user", 6'h25);
        ctl_ukey_en = 1'b0;
        expect_grant("R4 user key off", 3'b111);
        defaults(); pg_user = 1'b0; leaf_pkey = 4'd3;
        skey_rights = 32'h40; ctl_skey_en = 1'b1;
        expect_fault("R6 sup key fault", 6'h21);
        defaults(); pg_user = 1'b0; leaf_pkey = 4'd3;
        ukey_rights = 32'h40; ctl_ukey_en = 1'b1;
        expect_grant("R4 user word ignored for sup page", 3'b111);
        defaults(); priv_user = 1'b1; acc_type = 2'd1; leaf_pkey = 4'd2;
        ukey_rights = 32'h20; ctl_ukey_en = 1'b1;
        expect_fault("R5 write disable user store", 6'h27);
        defaults(); pg_user = 1'b0; leaf_pkey = 4'd2;
        skey_rights = 32'h20; ctl_skey_en = 1'b1;
        expect_grant("R5 wd ignored sup wp off", 3'b111);
        ctl_wp = 1'b1;
        expect_grant("R5 wd applied wp on", 3'b101);
        defaults(); priv_user = 1'b1; acc_type = 2'd2; leaf_pkey = 4'd3;
        ukey_rights = 32'h40; ctl_ukey_en = 1'b1;
        expect_grant("R6 fetch through ad key", 3'b100);
    endtask

    task automatic t_ad_update();
        defaults(); leaf_accessed = 1'b0;
        step();
        chk("R7 load A clear acc", upd_accessed, 1'b1);
        chk("R7 load A clear dirty", upd_dirty, 1'b0);
        chk("R7 load A clear wb", upd_writeback, 1'b1);
        defaults();
        step();
        chk("R7 load A set wb", upd_writeback, 1'b0);
        defaults(); acc_type = 2'd1; leaf_dirty = 1'b0;
        step();
        chk("R7 store D clear dirty", upd_dirty, 1'b1);
        chk("R7 store D clear wb", upd_writeback, 1'b1);
        chk("R8 store keeps W", rsp_perm, 3'b111);
        defaults(); acc_type = 2'd1;
        step();
        chk("R7 store clean wb", upd_writeback, 1'b0);
        defaults(); leaf_dirty = 1'b0;
        expect_grant("R8 load clean drops W", 3'b101);
    endtask

    task automatic t_walk_faults();
        defaults(); walk_np = 1'b1; acc_type = 2'd1; priv_user = 1'b1;
        expect_fault("R10 np user store", 6'h06);
        defaults(); walk_rsvd = 1'b1;
        expect_fault("R10 rsvd sup load", 6'h08);
        walk_np = 1'b1;
        expect_fault("R10 np over rsvd", 6'h00);
        defaults(); walk_np = 1'b1; priv_user = 1'b1; pg_user = 1'b0;
        expect_fault("R10 np over prot", 6'h04);
        chk("R8 fault perm zero", rsp_perm, 3'b000);
    endtask

    task automatic t_idle();
        defaults(); req_valid = 1'b0;
        step();
        chk("R12 idle valid", rsp_valid, 1'b0);
        chk("R12 idle grant", rsp_grant, 1'b0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        defaults(); req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R12 reset valid", rsp_valid, 1'b0);
        chk("R12 reset fault", rsp_fault, 1'b0);
        rst_n = 1'b1;
        t_user_on_sup();
        t_read_rule();
        t_write_rule();
        t_exec_rule();
        t_keys();
        t_ad_update();
        t_walk_faults();
        t_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule